// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits behind a local-bus window that software uses to reach the configuration space of devices on a PCI segment. Each access presents a 16-bit window offset and a byte, halfword or word size. A configuration-mapping value, held elsewhere, supplies the upper half of a 32-bit local address. The translator splits that local address into a one-hot device-select field, a function number and a register number. It then builds a type-0 style configuration address that carries the bus number, the device index, the function, the register and an enable flag.

The result is registered. One cycle after a request strobe, the block reports whether the access may go ahead. For an access that is refused, it provides the all-ones fill that a read must return. For an access that is allowed, it pulses a strobe that tells the host to clear its received-master-abort and received-target-abort status bits. The PCI bus cycle itself is carried out by a neighbouring block that consumes these outputs.

Top module: `cfg_addr_xlate`

## Requirements
- R1: After reset, and before any request, `rsp_valid`, `rsp_pass`, `status_clr`, `idsel_err` and `align_err` are 0.
- R2: Every cycle in which `req_valid` is 1 produces `rsp_valid` = 1 exactly one clock later. A cycle without a request produces `rsp_valid` = 0 one clock later, and in that case every other output is also 0.
- R3: The local address is `{map_cfg[15:0], req_addr[15:0]}`. Its bits [31:11] form the device-select field, and the device number is the index of the lowest set bit in that field (bit 11 of the local address gives device 0).
- R4: For an allowed access, `cfg_addr[10:8]` equals local bits [10:8] (the function), `cfg_addr[7:2]` equals local bits [7:2] (the register), and `cfg_addr[1:0]` is 0.
- R5: For an allowed access, `cfg_addr[23:16]` equals `bus_num`, `cfg_addr[15:11]` holds the device number, `cfg_addr[31]` is 1 and `cfg_addr[30:24]` is 0.
- R6: If `map_cfg[16]` is 1, the access is refused: `rsp_pass` = 0 and `cfg_addr` = 0.
- R7: If the device-select field is all zero, `idsel_err` = 1 and the access is refused. `idsel_err` reflects only this condition, including when R6 also refuses the access.
- R8: Size codes are 0 for byte, 1 for halfword, 2 for word and 3 for reserved. A halfword needs `req_addr[0]` = 0, a word needs `req_addr[1:0]` = 0, and code 3 is always invalid. Any violation sets `align_err` and refuses the access.
- R9: A refused read (`req_write` = 0) returns `rd_fill` = 0xFF, 0xFFFF or 0xFFFFFFFF for byte, halfword or word (all ones for code 3). `rd_fill` is 0 for writes and for allowed reads.
- R10: `status_clr` is 1 for exactly the responses that have `rsp_pass` = 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | 16 | Offset within the configuration window |
| map_cfg | input | 17 | [15:0] upper local address, [16] block |
| bus_num | input | 8 | Bus number placed in the output address |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_pass | output | 1 | Access may proceed |
| cfg_addr | output | 32 | Composed configuration address, 0 if refused |
| rd_fill | output | 32 | Read data to return for a refused read |
| idsel_err | output | 1 | Device-select field was all zero |
| align_err | output | 1 | Size or alignment violation |
| status_clr | output | 1 | Clear received-abort status bits |

## Verification
The hardest case to reach from the ports is an empty device-select field. It needs all sixteen mapping bits and the top five offset bits to be zero at the same time, so random stimulus almost never produces it. Directed accesses create it, with the block bit both clear and set, and at each access size. The other edge of the priority encode is also directed: a single select bit at the top of the field, and several bits set together, to confirm that the lowest one wins. Random accesses then mix block states, sizes and misaligned offsets against a model computed in the bench.

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate #(
  parameter int OFS_W = 16,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic [OFS_W-1:0] req_addr,
  input  logic [OFS_W:0]   map_cfg,
  input  logic [BUS_W-1:0] bus_num,
  output logic             rsp_valid,
  output logic             rsp_pass,
  output logic [31:0]      cfg_addr,
  output logic [31:0]      rd_fill,
  output logic             idsel_err,
  output logic             align_err,
  output logic             status_clr
);
  localparam int LOC_W = 2 * OFS_W;
  localparam int SEL_W = LOC_W - 11;

  logic [LOC_W-1:0] loc;
  logic [SEL_W-1:0] sel;
  logic [4:0]       dev;
  logic             sel_none, align_ok, blocked;
  logic [31:0]      fill_n, addr_n;

  assign loc      = {map_cfg[OFS_W-1:0], req_addr};
  assign sel      = loc[LOC_W-1:11];
  assign sel_none = (sel == '0);

  always_comb begin
    dev = '0;
    for (int i = SEL_W - 1; i >= 0; i--)
      if (sel[i]) dev = 5'(i);
  end

  always_comb begin
    case (req_size)
      2'd0:    align_ok = 1'b1;
      2'd1:    align_ok = ~req_addr[0];
      2'd2:    align_ok = (req_addr[1:0] == 2'b00);
      default: align_ok = 1'b0;
    endcase
  end

  assign blocked = map_cfg[OFS_W] | sel_none | ~align_ok;

  always_comb begin
    case (req_size)
      2'd0:    fill_n = 32'h0000_00FF;
      2'd1:    fill_n = 32'h0000_FFFF;
      default: fill_n = 32'hFFFF_FFFF;
    endcase
    if (!blocked || req_write) fill_n = '0;
  end

  assign addr_n = blocked ? 32'd0
                : {1'b1, 7'd0, bus_num, dev, loc[10:8], loc[7:2], 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_pass   <= 1'b0;
      cfg_addr   <= '0;
      rd_fill    <= '0;
      idsel_err  <= 1'b0;
      align_err  <= 1'b0;
      status_clr <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_pass   <= req_valid & ~blocked;
      cfg_addr   <= req_valid ? addr_n : '0;
      rd_fill    <= req_valid ? fill_n : '0;
      idsel_err  <= req_valid & sel_none;
      align_err  <= req_valid & ~align_ok;
      status_clr <= req_valid & ~blocked;
    end
  end
endmodule

// File: rtl/cfg_addr_xlate_chk.sv
module cfg_addr_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [1:0]  req_size,
  input logic [15:0] req_addr,
  input logic [16:0] map_cfg,
  input logic [7:0]  bus_num,
  input logic        rsp_valid,
  input logic        rsp_pass,
  input logic [31:0] cfg_addr,
  input logic [31:0] rd_fill,
  input logic        idsel_err,
  input logic        align_err,
  input logic        status_clr
);
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && cfg_addr == 32'd0 && rd_fill == 32'd0));
  p_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pass |-> (cfg_addr[31] && cfg_addr[30:24] == 7'd0));
  p_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !map_cfg[16] && req_size == 2'd0 && req_addr[15:11] != 5'd0)
      |=> (rsp_pass && cfg_addr[23:16] == $past(bus_num)));
  p_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && map_cfg[16]) |=> (!rsp_pass && cfg_addr == 32'd0));
  p_empty_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && map_cfg[15:0] == 16'd0 && req_addr[15:11] == 5'd0)
      |=> (idsel_err && !rsp_pass));
  p_reserved_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd3) |=> (align_err && !rsp_pass));
  p_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pass |-> (rd_fill == 32'd0));
  p_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr == (rsp_valid && rsp_pass));
endmodule

bind cfg_addr_xlate cfg_addr_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_size(req_size), .req_addr(req_addr), .map_cfg(map_cfg),
  .bus_num(bus_num), .rsp_valid(rsp_valid), .rsp_pass(rsp_pass),
  .cfg_addr(cfg_addr), .rd_fill(rd_fill), .idsel_err(idsel_err),
  .align_err(align_err), .status_clr(status_clr)
);

// File: tb/cfg_addr_xlate_tb.sv
module cfg_addr_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic [15:0] req_addr = '0;
  logic [16:0] map_cfg = '0;
  logic [7:0]  bus_num = '0;
  logic        rsp_valid, rsp_pass, idsel_err, align_err, status_clr;
  logic [31:0] cfg_addr, rd_fill;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfg_addr_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .map_cfg(map_cfg),
    .bus_num(bus_num), .rsp_valid(rsp_valid), .rsp_pass(rsp_pass),
    .cfg_addr(cfg_addr), .rd_fill(rd_fill), .idsel_err(idsel_err),
    .align_err(align_err), .status_clr(status_clr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic access(bit wr, logic [1:0] sz, logic [15:0] ofs,
                        logic [16:0] mc, logic [7:0] bn);
    logic [31:0] loc, e_addr, e_fill;
    logic [20:0] sel;
    logic [4:0]  dev;
    bit al_ok, sel_zero, blk;
    loc = {mc[15:0], ofs};
    sel = loc[31:11];
    sel_zero = (sel == 21'd0);
    dev = 5'd0;
    for (int i = 0; i < 21; i++)
      if (sel[i]) begin dev = 5'(i); break; end
    al_ok = (sz == 2'd0) || (sz == 2'd1 && !ofs[0]) || (sz == 2'd2 && ofs[1:0] == 2'b00);
    blk = mc[16] || sel_zero || !al_ok;
    e_addr = blk ? 32'd0 : (32'h8000_0000 | ({24'd0, bn} << 16) | ({27'd0, dev} << 11)
                            | (loc & 32'h0000_07FC));
    if (!blk || wr) e_fill = 32'd0;
    else if (sz == 2'd0) e_fill = 32'hFF;
    else if (sz == 2'd1) e_fill = 32'hFFFF;
    else e_fill = 32'hFFFF_FFFF;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz;
    req_addr = ofs; map_cfg = mc; bus_num = bn;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk("R3 R4 R5 R6 cfg_addr", cfg_addr, e_addr);
    chk("R6 R7 R8 rsp_pass", {31'd0, rsp_pass}, {31'd0, !blk});
    chk("R7 idsel_err", {31'd0, idsel_err}, {31'd0, sel_zero});
    chk("R8 align_err", {31'd0, align_err}, {31'd0, !al_ok});
    chk("R9 rd_fill", rd_fill, e_fill);
    chk("R10 status_clr", {31'd0, status_clr}, {31'd0, !blk});
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 rsp_pass", {31'd0, rsp_pass}, 32'd0);
    chk("R1 status_clr", {31'd0, status_clr}, 32'd0);
    chk("R1 errs", {30'd0, idsel_err, align_err}, 32'd0);
    // R3 R4 R5 basic: bit 11 -> device 0
    access(1'b0, 2'd2, 16'h0804, 17'h00000, 8'h00);
    // R3 lowest of several select bits wins
    access(1'b0, 2'd0, 16'hF73D, 17'h00000, 8'h5A);
    // R3 top select bit only -> device 20
    access(1'b1, 2'd1, 16'h0002, 17'h08000, 8'hFF);
    // R6 blocked read, each width
    access(1'b0, 2'd0, 16'h1000, 17'h10000, 8'h01);
    access(1'b0, 2'd1, 16'h1000, 17'h10000, 8'h01);
    access(1'b0, 2'd2, 16'h1000, 17'h10000, 8'h01);
    access(1'b1, 2'd2, 16'h1000, 17'h10000, 8'h01);
    // R7 empty select field
    access(1'b0, 2'd2, 16'h07FC, 17'h00000, 8'h03);
    access(1'b0, 2'd0, 16'h0001, 17'h10000, 8'h03);
    access(1'b1, 2'd1, 16'h0000, 17'h00000, 8'h03);
    // R8 alignment
    access(1'b0, 2'd1, 16'h2001, 17'h00000, 8'h07);
    access(1'b0, 2'd2, 16'h2002, 17'h00000, 8'h07);
    access(1'b0, 2'd3, 16'h2000, 17'h00000, 8'h07);
    access(1'b1, 2'd1, 16'h2002, 17'h00000, 8'h07);
    // R2 idle cycle after a request
    @(negedge clk);
    chk("R2 idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R2 idle cfg_addr", cfg_addr, 32'd0);
    chk("R10 idle status_clr", {31'd0, status_clr}, 32'd0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [16:0] mc;
      mc = 17'($urandom);
      mc[16] = ($urandom % 4) == 0;
      if (($urandom % 3) == 0) mc[15:0] = 16'd0;
      access(1'($urandom), 2'($urandom), 16'($urandom), mc, 8'($urandom));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule